// File: doc/BRIEF.md
# Split-Word Frequency Register Loader

This block holds two 24-bit frequency words: a start frequency and a per-step frequency increment. Software loads them 12 bits at a time through a 16-bit parallel write port. The top nibble of each write picks which half of which word is the target. The low 12 bits carry the payload. Serial shifting and control-register decoding happen upstream, so the block sees only a write strobe with its data.

A mode input picks one of two loading styles. In split mode, each half of each word is its own register, and a single write replaces one half. In combined mode, a low-half write is parked in a staging register. The next high-half write to the same word moves both halves into the destination in a single clock edge, so a sweep engine reading the words never sees a half-updated value. Changing the mode throws away anything still parked.

Top module: `freq_word_loader`

## Requirements
- R1: A synchronous active-high reset sets both words to zero and drops any parked half. A high-half write in combined mode right after reset leaves both words at zero.
- R2: The write address is wr_data[15:12] and the payload is wr_data[11:0]. The address codes are: 0x1 start low half, 0x2 start high half, 0x3 increment low half, 0x4 increment high half. A write to any other address changes neither word.
- R3: In split mode, a low-half write replaces bits [11:0] of its word at the next clock edge and keeps bits [23:12].
- R4: In split mode, a high-half write replaces bits [23:12] of its word at the next clock edge and keeps bits [11:0].
- R5: In combined mode, a low-half write changes neither output word.
- R6: In combined mode, a high-half write to the word whose low half is parked sets that word to {high payload, parked low} at the next edge, in one step.
- R7: In combined mode, a high-half write is ignored when no low half is parked for that word. A parked half for another word stays parked.
- R8: In combined mode, a newer low-half write replaces any parked half, including its target word.
- R9: A change of the mode input drops any parked half. A write in the same cycle as the change is handled under the new mode.
- R10: A commit consumes the parked half, so a repeated high-half write is ignored.
- R11: With wr_en low, neither word changes, whatever wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 16 | Address nibble [15:12] and payload [11:0] |
| combined_mode | input | 1 | 1 = combined two-write commit, 0 = split halves |
| start_word | output | 24 | Committed start frequency |
| incr_word | output | 24 | Committed frequency increment |

## Verification
Two functions can fall in the same cycle: a change of the mode input, which drops the parked half, and a write, which either parks a half or applies one. The bench provokes this by toggling the mode and issuing a write on the same clock edge. In one case the change goes from combined to split together with a high-half write, and the bench expects the high half to land on its own. In the other case the change goes from split back to combined together with a low-half write, and the bench expects the new half to stay parked and to commit with the next high-half write. Running the old mode's rule in that cycle, or clearing the new parked half, changes the words the bench sees.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam int unsigned NUM_WORDS = 2;
  localparam int unsigned IDX_START = 0;
  localparam int unsigned IDX_INCR  = 1;
  localparam int unsigned HALF_LO   = 0;
  localparam int unsigned HALF_HI   = 1;
endpackage

// File: rtl/fwl_addr_decode.sv
module fwl_addr_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_START_LO = 4'h1,
  parameter logic [ADDR_W-1:0] A_START_HI = 4'h2,
  parameter logic [ADDR_W-1:0] A_INCR_LO  = 4'h3,
  parameter logic [ADDR_W-1:0] A_INCR_HI  = 4'h4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        hit   // index = word*2 + half
);
  always_comb begin
    hit = '0;
    if (wr_en) begin
      hit[0] = (addr == A_START_LO);
      hit[1] = (addr == A_START_HI);
      hit[2] = (addr == A_INCR_LO);
      hit[3] = (addr == A_INCR_HI);
    end
  end
endmodule

// File: rtl/fwl_stage.sv
module fwl_stage #(
  parameter int unsigned HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld,
  input  logic              ld_sel,
  input  logic [HALF_W-1:0] ld_data,
  output logic              vld,
  output logic              sel,
  output logic [HALF_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      sel  <= 1'b0;
      data <= '0;
    end else if (ld) begin
      vld  <= 1'b1;
      sel  <= ld_sel;
      data <= ld_data;
    end else if (clr) begin
      vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/fwl_word_reg.sv
module fwl_word_reg #(
  parameter int unsigned HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [HALF_W-1:0]   lo_d,
  input  logic [HALF_W-1:0]   hi_d,
  output logic [2*HALF_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else begin
      if (lo_we) word[HALF_W-1:0]        <= lo_d;
      if (hi_we) word[2*HALF_W-1:HALF_W] <= hi_d;
    end
  end
endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader #(
  parameter int unsigned HALF_W = 12,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_START_LO = 4'h1,
  parameter logic [ADDR_W-1:0] A_START_HI = 4'h2,
  parameter logic [ADDR_W-1:0] A_INCR_LO  = 4'h3,
  parameter logic [ADDR_W-1:0] A_INCR_HI  = 4'h4,
  localparam int unsigned DATA_W = ADDR_W + HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              combined_mode,
  output logic [WORD_W-1:0] start_word,
  output logic [WORD_W-1:0] incr_word
);
  import fwl_pkg::*;

  logic [ADDR_W-1:0] addr;
  logic [HALF_W-1:0] payload;
  logic [3:0]        hit;
  logic              mode_q;
  logic              mode_chg;
  logic              stg_vld, stg_sel;
  logic [HALF_W-1:0] stg_data;
  logic              stg_ld, stg_ld_sel;
  logic [NUM_WORDS-1:0] commit;
  logic [NUM_WORDS-1:0] lo_we, hi_we;
  logic [HALF_W-1:0] lo_d [NUM_WORDS];
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  assign addr    = wr_data[DATA_W-1 -: ADDR_W];
  assign payload = wr_data[HALF_W-1:0];

  fwl_addr_decode #(
    .ADDR_W(ADDR_W), .A_START_LO(A_START_LO), .A_START_HI(A_START_HI),
    .A_INCR_LO(A_INCR_LO), .A_INCR_HI(A_INCR_HI)
  ) u_dec (
    .wr_en(wr_en), .addr(addr), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= combined_mode;
  end
  assign mode_chg = (combined_mode != mode_q);

  // A low-half write in combined mode parks the payload; the later of two wins.
  assign stg_ld     = combined_mode & (hit[IDX_START*2+HALF_LO] | hit[IDX_INCR*2+HALF_LO]);
  assign stg_ld_sel = hit[IDX_INCR*2+HALF_LO];

  fwl_stage #(.HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst(rst),
    .clr(mode_chg | (|commit)),
    .ld(stg_ld), .ld_sel(stg_ld_sel), .ld_data(payload),
    .vld(stg_vld), .sel(stg_sel), .data(stg_data)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign commit[w] = combined_mode & ~mode_chg & hit[w*2+HALF_HI]
                     & stg_vld & (stg_sel == 1'(w));
    assign lo_we[w]  = combined_mode ? commit[w] : hit[w*2+HALF_LO];
    assign hi_we[w]  = combined_mode ? commit[w] : hit[w*2+HALF_HI];
    assign lo_d[w]   = combined_mode ? stg_data : payload;

    fwl_word_reg #(.HALF_W(HALF_W)) u_reg (
      .clk(clk), .rst(rst),
      .lo_we(lo_we[w]), .hi_we(hi_we[w]),
      .lo_d(lo_d[w]), .hi_d(payload),
      .word(word_q[w])
    );
  end

  assign start_word = word_q[IDX_START];
  assign incr_word  = word_q[IDX_INCR];
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker #(
  parameter int unsigned HALF_W = 12,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_START_LO = 4'h1,
  parameter logic [ADDR_W-1:0] A_START_HI = 4'h2,
  parameter logic [ADDR_W-1:0] A_INCR_LO  = 4'h3,
  parameter logic [ADDR_W-1:0] A_INCR_HI  = 4'h4,
  localparam int unsigned DATA_W = ADDR_W + HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              combined_mode,
  input logic [WORD_W-1:0] start_word,
  input logic [WORD_W-1:0] incr_word
);
  logic [ADDR_W-1:0] a;
  logic              known, hi_addr;
  assign a       = wr_data[DATA_W-1 -: ADDR_W];
  assign hi_addr = (a == A_START_HI) || (a == A_INCR_HI);
  assign known   = hi_addr || (a == A_START_LO) || (a == A_INCR_LO);

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (start_word == '0 && incr_word == '0));

  a_r2_unknown_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !known) |=> ($stable(start_word) && $stable(incr_word)));

  a_r3_split_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !combined_mode && a == A_START_LO) |=>
      (start_word[WORD_W-1:HALF_W] == $past(start_word[WORD_W-1:HALF_W]) &&
       start_word[HALF_W-1:0] == $past(wr_data[HALF_W-1:0]) && $stable(incr_word)));

  a_r4_split_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !combined_mode && a == A_INCR_HI) |=>
      (incr_word[HALF_W-1:0] == $past(incr_word[HALF_W-1:0]) &&
       incr_word[WORD_W-1:HALF_W] == $past(wr_data[HALF_W-1:0]) && $stable(start_word)));

  a_r5_combined_hold: assert property (@(posedge clk) disable iff (rst)
    (combined_mode && !(wr_en && hi_addr)) |=> ($stable(start_word) && $stable(incr_word)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(start_word) && $stable(incr_word)));
endmodule

bind freq_word_loader fwl_checker #(
  .HALF_W(HALF_W), .ADDR_W(ADDR_W), .A_START_LO(A_START_LO), .A_START_HI(A_START_HI),
  .A_INCR_LO(A_INCR_LO), .A_INCR_HI(A_INCR_HI)
) u_chk (.*);

// File: tb/sim_freq_word_loader.sv
module sim_freq_word_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        combined_mode = 1'b0;
  logic [23:0] start_word, incr_word;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  freq_word_loader u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .combined_mode(combined_mode), .start_word(start_word), .incr_word(incr_word)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic both(input string req, input logic [23:0] es, input logic [23:0] ei);
    check({req, " start"}, start_word, es);
    check({req, " incr"}, incr_word, ei);
  endtask

  // Drive at negedge, let one posedge pass, return at the next negedge.
  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    wr_en = 1'b1; wr_data = {a, d};
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    both("R1 reset", 24'h0, 24'h0);
    combined_mode = 1'b1; idle();
    wr(4'h2, 12'h5A5);
    both("R1 no parked half after reset", 24'h0, 24'h0);
    combined_mode = 1'b0; idle();
  endtask

  task automatic t_split();
    wr(4'h1, 12'hABC); both("R3 start low", 24'h000ABC, 24'h0);
    wr(4'h2, 12'h123); both("R4 start high", 24'h123ABC, 24'h0);
    wr(4'h3, 12'h0F0); both("R2 incr low addr", 24'h123ABC, 24'h0000F0);
    wr(4'h4, 12'hFFF); both("R4 incr high", 24'h123ABC, 24'hFFF0F0);
    wr(4'h1, 12'h555); both("R3 low keeps high", 24'h123555, 24'hFFF0F0);
  endtask

  task automatic t_ignore();
    wr(4'h0, 12'h999); both("R2 addr 0 ignored", 24'h123555, 24'hFFF0F0);
    wr(4'hF, 12'h999); both("R2 addr F ignored", 24'h123555, 24'hFFF0F0);
    wr_en = 1'b0; wr_data = {4'h1, 12'h777}; @(negedge clk);
    wr_data = {4'h4, 12'h777}; @(negedge clk); wr_data = '0;
    both("R11 strobe low", 24'h123555, 24'hFFF0F0);
  endtask

  task automatic t_combined();
    combined_mode = 1'b1; idle();
    wr(4'h1, 12'h111); both("R5 low parked only", 24'h123555, 24'hFFF0F0);
    wr(4'h2, 12'h222); both("R6 commit", 24'h222111, 24'hFFF0F0);
    wr(4'h2, 12'h333); both("R10 repeat high ignored", 24'h222111, 24'hFFF0F0);
    wr(4'h1, 12'h444); wr(4'h1, 12'h555); wr(4'h2, 12'h666);
    both("R8 newer low wins", 24'h666555, 24'hFFF0F0);
  endtask

  task automatic t_cross();
    wr(4'h1, 12'h777);
    wr(4'h4, 12'h888); both("R7 high to other word ignored", 24'h666555, 24'hFFF0F0);
    wr(4'h2, 12'h999); both("R7 parked half survives", 24'h999777, 24'hFFF0F0);
    wr(4'h3, 12'hAAA); wr(4'h1, 12'hBBB);
    wr(4'h4, 12'hCCC); both("R8 retarget drops incr", 24'h999777, 24'hFFF0F0);
    wr(4'h2, 12'hDDD); both("R8 retarget commits start", 24'hDDDBBB, 24'hFFF0F0);
  endtask

  task automatic t_mode();
    wr(4'h1, 12'h123);
    combined_mode = 1'b0; idle(); idle();
    combined_mode = 1'b1; idle();
    wr(4'h2, 12'h456); both("R9 toggle drops parked half", 24'hDDDBBB, 24'hFFF0F0);
    wr(4'h1, 12'h321);
    combined_mode = 1'b0; wr(4'h2, 12'h0AB);
    both("R9 same-cycle split write", 24'h0ABBBB, 24'hFFF0F0);
    combined_mode = 1'b1; wr(4'h1, 12'h0CD);
    both("R9 same-cycle combined park", 24'h0ABBBB, 24'hFFF0F0);
    wr(4'h2, 12'h0EF); both("R9 parked half commits", 24'h0EF0CD, 24'hFFF0F0);
  endtask

  task automatic t_reset_again();
    rst = 1'b1; idle(); rst = 1'b0;
    both("R1 mid-run reset", 24'h0, 24'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_split();
    t_ignore();
    t_combined();
    t_cross();
    t_mode();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule